// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Words of `DATA_W` bits go in on the write clock and come out, in order, into a registered output on the read clock. The storage depth is `2**ADDR_W` words. Four active-low level flags report the fill state. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. Each flag is computed from the local pointer and a synchronized Gray-coded copy of the remote pointer. A flag can therefore clear late, but it never clears early.

The write side acts as a stream sink, with `full_n` as its ready. A word is taken on a write-clock edge when `wr_en1_n` is low, `wr_en2_ld` is high and `full_n` is high. If `full_n` is low, the source must hold its data and retry. The read side acts as a stream source, with `empty_n` as its valid. A read-clock edge with both read enables low and `empty_n` high moves the next word into the output register. A read attempt while `empty_n` is low does nothing.

The level of `wr_en2_ld` while reset is low picks the operating mode. A high level selects two-enable mode, where the pin is only a second write enable. A low level selects offset-load mode, where a low level on the pin hands both clocks to an external offset register block. In that mode the FIFO ignores both writes and reads while the pin is low. The two offsets arrive on input ports. The output enable is modelled by a valid bit and by zeroed data.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge exactly when `wr_en1_n`=0, `wr_en2_ld`=1 and `full_n`=1. With `wr_en2_ld`=0, nothing is stored in either mode.
- R2: A write attempted while `full_n`=0 is dropped and leaves the stored contents and their order unchanged.
- R3: A rising `rd_clk` edge with `rd_en1_n`=0, `rd_en2_n`=0 and `empty_n`=1 loads the oldest stored word into the output register. That word is visible on `rd_data` after that edge.
- R4: A read attempted while `empty_n`=0 is ignored, and `rd_data` keeps the last word read.
- R5: `wr_en2_ld` is sampled while `rst_n`=0. A 1 gives two-enable mode (`prog_mode`=0), where reads ignore the pin. A 0 gives offset-load mode (`prog_mode`=1), where reads are also blocked while the pin is 0. The mode stays fixed until the next reset.
- R6: `empty_n` is 0 when no unread word is held. It is updated only on `rd_clk`. It falls on the same edge as the read that takes the last word.
- R7: `almost_empty_n` is 0 when the unread count is at most `ae_offset`, and 1 when the count is `ae_offset`+1 or more. It is updated only on `rd_clk`.
- R8: `full_n` is 0 when `2**ADDR_W` words are held. It is updated only on `wr_clk`. It falls on the edge of the write that fills the last slot.
- R9: `almost_full_n` is 0 when the count is at least `2**ADDR_W - af_offset`. It is updated only on `wr_clk`.
- R10: After reset, `empty_n`=0, `almost_empty_n`=0, `full_n`=1, `almost_full_n`=1, and the output register holds 0.
- R11: With `out_en_n`=1, `rd_valid`=0 and `rd_data`=0. With `out_en_n`=0, `rd_valid`=1 and `rd_data` shows the output register.
- R12: Words leave in the order they were accepted, even when both clocks run continuously at unrelated rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset for both sides; mode is sampled while low |
| wr_data | input | DATA_W | Word to store |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (active high) or offset-load control; mode pin during reset |
| full_n | output | 1 | Low when full; write-side ready |
| almost_full_n | output | 1 | Low at or above the almost-full threshold |
| rd_en1_n | input | 1 | Read enable one, active low |
| rd_en2_n | input | 1 | Read enable two, active low |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W | Output register contents, zero while disabled |
| rd_valid | output | 1 | High while the output is enabled |
| empty_n | output | 1 | Low when empty; read-side valid |
| almost_empty_n | output | 1 | Low at or below the almost-empty offset |
| ae_offset | input | ADDR_W | Almost-empty offset |
| af_offset | input | ADDR_W | Almost-full offset |
| prog_mode | output | 1 | High when offset-load mode was chosen at reset |

## Verification
The bench builds the block with `DATA_W`=9 and `ADDR_W`=4, which gives a 16-word store. With that depth, filling the buffer completely, crossing the almost-full threshold at `af_offset`=3 and hitting the full boundary take only a few dozen writes. The almost-empty boundary is exercised at an offset of 7, and the two clocks run at periods of 10 and 14 time units. Each of the two modes is entered through its own reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_DUAL_WE = 1'b0,
    MODE_PROG    = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dcf_gray_sync.sv
// Two-stage synchronizer for a Gray-coded pointer, with binary decode.
module dcf_gray_sync #(
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_dec
    assign bin_out[i] = ^stage2[PW-1:i];
  end
endmodule

// File: rtl/dcf_ram.sv
// Storage array: clocked write port, combinational read port.
module dcf_ram #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write pointer, mode latch, full and almost-full flags (write clock only).
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int PW = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wr_en1_n,
  input  logic              wr_en2_ld,
  input  logic [PW-1:0]     rd_bin_s,
  input  logic [ADDR_W-1:0] af_offset,
  output logic              wr_fire,
  output logic [PW-1:0]     wr_bin,
  output logic [PW-1:0]     wr_gray,
  output logic              full_n,
  output logic              af_n,
  output fifo_mode_e        mode
);
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << ADDR_W;

  logic [PW-1:0] bin_nxt, count_nxt;

  assign wr_fire   = !wr_en1_n && wr_en2_ld && full_n;
  assign bin_nxt   = wr_bin + PW'(wr_fire);
  assign count_nxt = bin_nxt - rd_bin_s;

  always_ff @(posedge wr_clk) begin
    if (!rst_n) mode <= wr_en2_ld ? MODE_DUAL_WE : MODE_PROG;
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      full_n  <= 1'b1;
      af_n    <= 1'b1;
    end else begin
      wr_bin  <= bin_nxt;
      wr_gray <= bin_nxt ^ (bin_nxt >> 1);
      full_n  <= (count_nxt != DEPTH_P);
      af_n    <= (count_nxt < (DEPTH_P - {1'b0, af_offset}));
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read pointer, output register, empty and almost-empty flags (read clock only).
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10,
  localparam int PW = ADDR_W + 1
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              ld_pin,
  input  logic [PW-1:0]     wr_bin_s,
  input  logic [ADDR_W-1:0] ae_offset,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PW-1:0]     rd_bin,
  output logic [PW-1:0]     rd_gray,
  output logic [DATA_W-1:0] rd_q,
  output logic              empty_n,
  output logic              ae_n
);
  fifo_mode_e    mode_r;
  logic          rd_fire, offset_access;
  logic [PW-1:0] bin_nxt, count_nxt;

  always_ff @(posedge rd_clk) begin
    if (!rst_n) mode_r <= ld_pin ? MODE_DUAL_WE : MODE_PROG;
  end

  assign offset_access = (mode_r == MODE_PROG) && !ld_pin;
  assign rd_fire   = !rd_en1_n && !rd_en2_n && empty_n && !offset_access;
  assign bin_nxt   = rd_bin + PW'(rd_fire);
  assign count_nxt = wr_bin_s - bin_nxt;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
      rd_q    <= '0;
      empty_n <= 1'b0;
      ae_n    <= 1'b0;
    end else begin
      rd_bin  <= bin_nxt;
      rd_gray <= bin_nxt ^ (bin_nxt >> 1);
      if (rd_fire) rd_q <= mem_rdata;
      empty_n <= (count_nxt != '0);
      ae_n    <= (count_nxt > {1'b0, ae_offset});
    end
  end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcf_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en1_n,
  input  logic              wr_en2_ld,
  output logic              full_n,
  output logic              almost_full_n,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty_n,
  output logic              almost_empty_n,
  input  logic [ADDR_W-1:0] ae_offset,
  input  logic [ADDR_W-1:0] af_offset,
  output logic              prog_mode
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wr_ptr, wr_gray, rd_ptr, rd_gray, wr_ptr_s, rd_ptr_s;
  logic [DATA_W-1:0] mem_rdata, rd_q;
  logic              wr_fire;
  fifo_mode_e        mode;

  dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
    .rd_bin_s(rd_ptr_s), .af_offset(af_offset), .wr_fire(wr_fire),
    .wr_bin(wr_ptr), .wr_gray(wr_gray), .full_n(full_n), .af_n(almost_full_n),
    .mode(mode)
  );

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(wr_clk), .we(wr_fire), .waddr(wr_ptr[ADDR_W-1:0]), .wdata(wr_data),
    .raddr(rd_ptr[ADDR_W-1:0]), .rdata(mem_rdata)
  );

  dcf_gray_sync #(.PW(PW)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(wr_ptr_s)
  );

  dcf_gray_sync #(.PW(PW)) u_sync_r2w (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rd_gray), .bin_out(rd_ptr_s)
  );

  dcf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .ld_pin(wr_en2_ld), .wr_bin_s(wr_ptr_s), .ae_offset(ae_offset),
    .mem_rdata(mem_rdata), .rd_bin(rd_ptr), .rd_gray(rd_gray), .rd_q(rd_q),
    .empty_n(empty_n), .ae_n(almost_empty_n)
  );

  assign prog_mode = (mode == MODE_PROG);
  assign rd_valid  = !out_en_n;
  assign rd_data   = out_en_n ? '0 : rd_q;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10,
  localparam int PW = ADDR_W + 1
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              full_n,
  input logic              almost_full_n,
  input logic              empty_n,
  input logic              almost_empty_n,
  input logic              prog_mode,
  input logic [PW-1:0]     wr_ptr,
  input logic [PW-1:0]     rd_ptr,
  input logic [DATA_W-1:0] rd_q
);
  p_wr_step_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !$stable(wr_ptr) |-> (wr_ptr - $past(wr_ptr)) == PW'(1));

  p_no_overflow_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wr_ptr));

  p_rd_step_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !$stable(rd_ptr) |-> (rd_ptr - $past(rd_ptr)) == PW'(1));

  p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_ptr));

  p_hold_last_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rd_q));

  p_mode_fixed_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $stable(prog_mode));

  p_empty_in_ae_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n);

  p_full_in_af_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !almost_full_n);
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .full_n(full_n),
  .almost_full_n(almost_full_n), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
  .prog_mode(prog_mode), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_q(rd_q)
);

// File: tb/dcfifo_pflag_bench.sv
module dcfifo_pflag_bench;
  localparam int DATA_W     = 9;
  localparam int ADDR_W     = 4;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;

  logic              wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_en1_n = 1, wr_en2_ld = 1, rd_en1_n = 1, rd_en2_n = 1, out_en_n = 0;
  logic [ADDR_W-1:0] ae_offset = 7, af_offset = 7;
  logic              full_n, almost_full_n, empty_n, almost_empty_n, rd_valid, prog_mode;
  logic [DATA_W-1:0] rd_data;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dcfifo_pflag #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dcfifo_pflag (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld), .full_n(full_n),
    .almost_full_n(almost_full_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .out_en_n(out_en_n), .rd_data(rd_data), .rd_valid(rd_valid), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .ae_offset(ae_offset), .af_offset(af_offset),
    .prog_mode(prog_mode)
  );

  int tests = 0, fails = 0;
  bit model_prog = 0;
  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] last_rd = '0;
  int wr_count = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
  endtask

  task automatic do_reset(input bit ld_level);
    @(negedge wr_clk);
    rst_n = 0; wr_en2_ld = ld_level;
    wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1;
    model_prog = !ld_level;
    q.delete(); last_rd = '0; wr_count = 0;
    wr_en2_ld = 1;
    settle();
  endtask

  // write one word; acceptance predicted from full_n and the load pin (R1, R2)
  task automatic wr_word(input logic [DATA_W-1:0] d, input bit ld);
    bit acc;
    @(negedge wr_clk);
    wr_data = d; wr_en1_n = 0; wr_en2_ld = ld;
    acc = full_n && ld;
    @(negedge wr_clk);
    wr_en1_n = 1; wr_en2_ld = 1;
    if (acc) begin q.push_back(d); wr_count++; end
  endtask

  // read one word; output compared with the queue model (R3, R4)
  task automatic rd_word(input bit ld, input string req);
    bit acc;
    logic [DATA_W-1:0] exp;
    @(negedge rd_clk);
    rd_en1_n = 0; rd_en2_n = 0; wr_en2_ld = ld;
    acc = empty_n && !(model_prog && !ld);
    @(negedge rd_clk);
    rd_en1_n = 1; rd_en2_n = 1; wr_en2_ld = 1;
    if (acc && q.size() > 0) last_rd = q.pop_front();
    exp = last_rd;
    chk(rd_data == exp, req, int'(rd_data), int'(exp));
  endtask

  task automatic t_reset_state();
    do_reset(1);
    chk(empty_n == 0, "R10 empty_n", empty_n, 0);
    chk(almost_empty_n == 0, "R10 almost_empty_n", almost_empty_n, 0);
    chk(full_n == 1, "R10 full_n", full_n, 1);
    chk(almost_full_n == 1, "R10 almost_full_n", almost_full_n, 1);
    chk(rd_data == 0, "R10 rd_data", int'(rd_data), 0);
    chk(prog_mode == 0, "R5 two-enable mode", prog_mode, 0);
  endtask

  task automatic t_almost_empty();
    ae_offset = 7;
    for (int i = 0; i < 5; i++) wr_word(DATA_W'(9'h40 + i), 1);
    settle();
    chk(empty_n == 1, "R6 not empty", empty_n, 1);
    chk(almost_empty_n == 0, "R7 five words vs offset 7", almost_empty_n, 0);
    for (int i = 5; i < 8; i++) wr_word(DATA_W'(9'h40 + i), 1);
    settle();
    chk(almost_empty_n == 1, "R7 eight words vs offset 7", almost_empty_n, 1);
    for (int i = 0; i < 8; i++) begin
      rd_word(1, "R3 drain order");
      chk(almost_empty_n == (q.size() > 7), "R7 drain level", almost_empty_n, int'(q.size() > 7));
      chk(empty_n == (q.size() != 0), "R6 drain empty", empty_n, int'(q.size() != 0));
    end
    rd_word(1, "R4 read while empty holds last");
    chk(rd_data == 9'h47, "R4 last word", int'(rd_data), 9'h47);
  endtask

  task automatic t_full_bound();
    af_offset = 3;
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(DATA_W'(9'h100 + i), 1);
      chk(almost_full_n == (q.size() < DEPTH - 3), "R9 threshold", almost_full_n,
          int'(q.size() < DEPTH - 3));
      chk(full_n == (q.size() != DEPTH), "R8 full edge", full_n, int'(q.size() != DEPTH));
    end
    wr_word(9'h1AA, 1);
    chk(q.size() == DEPTH, "R2 write dropped while full", q.size(), DEPTH);
    settle();
    for (int i = 0; i < DEPTH; i++) rd_word(1, "R2 contents intact after full");
    chk(empty_n == 0, "R6 empty after drain", empty_n, 0);
    af_offset = 7;
  endtask

  task automatic t_out_enable();
    @(negedge rd_clk);
    out_en_n = 1;
    #1;
    chk(rd_valid == 0, "R11 valid low when disabled", rd_valid, 0);
    chk(rd_data == 0, "R11 data zero when disabled", int'(rd_data), 0);
    out_en_n = 0;
    #1;
    chk(rd_valid == 1 && rd_data == last_rd, "R11 enabled shows register", int'(rd_data), int'(last_rd));
  endtask

  task automatic t_prog_mode();
    do_reset(0);
    chk(prog_mode == 1, "R5 offset-load mode latched", prog_mode, 1);
    wr_word(9'h0A1, 1);
    wr_word(9'h0A2, 1);
    settle();
    rd_word(0, "R5 read blocked while load pin low");
    chk(rd_data == 0, "R5 blocked read leaves output", int'(rd_data), 0);
    rd_word(1, "R5 read with load pin high");
    wr_word(9'h0A3, 0);
    settle();
    rd_word(1, "R1 load-pin-low write ignored");
    rd_word(1, "R4 empty after ignored write");
    chk(rd_data == 9'h0A2 && empty_n == 0, "R1 no extra word", int'(rd_data), 9'h0A2);
  endtask

  task automatic t_dual_enable();
    do_reset(1);
    chk(prog_mode == 0, "R5 two-enable mode latched", prog_mode, 0);
    wr_word(9'h055, 0);
    wr_word(9'h066, 1);
    settle();
    rd_word(0, "R5 read ignores second enable in two-enable mode");
    chk(rd_data == 9'h066, "R1 second enable low blocks write", int'(rd_data), 9'h066);
    chk(empty_n == 0, "R6 empty after single word", empty_n, 0);
  endtask

  task automatic t_stream();
    int got = 0;
    int bad = 0;
    fork
      begin
        int sent = 0;
        while (sent < 60) begin
          @(negedge wr_clk);
          if (($urandom % 4) != 0) begin
            wr_data = DATA_W'(sent * 7 + 3);
            wr_en1_n = 0;
            if (full_n) begin q.push_back(wr_data); sent++; end
          end else wr_en1_n = 1;
        end
        @(negedge wr_clk);
        wr_en1_n = 1;
      end
      begin
        logic [DATA_W-1:0] exp;
        while (got < 60) begin
          @(negedge rd_clk);
          if (rd_en1_n == 0 && q.size() > 0 && got > 0) begin end
          rd_en1_n = (($urandom % 3) == 0);
          rd_en2_n = 0;
          if (!rd_en1_n && empty_n) begin
            @(negedge rd_clk);
            rd_en1_n = 1;
            exp = q.pop_front();
            if (rd_data != exp) begin
              bad++;
              chk(0, "R12 stream order", int'(rd_data), int'(exp));
            end
            got++;
          end
        end
        rd_en1_n = 1; rd_en2_n = 1;
      end
    join
    chk(bad == 0 && got == 60, "R12 stream complete", got, 60);
  endtask

  bit done = 0;

  initial begin
    t_reset_state();
    t_almost_empty();
    t_full_bound();
    t_out_enable();
    t_prog_mode();
    t_dual_enable();
    t_stream();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule